// File: doc/BRIEF.md
# Truncated Timestamp Seconds Extender

A packet timestamp arrives as a 32-bit word. Only the two lowest bits of the seconds count travel with it, so the stamp alone cannot give the full time. This block widens the stamp to a full 48-bit seconds value plus a 30-bit nanoseconds value. It does this by comparing the stamp's seconds bits with a locally held reference seconds value.

The reference holds the time-of-day seconds. Other logic reloads it through a simple write port about every two seconds. Each conversion samples the reference once, in the cycle the stamp is accepted, and keeps that copy through the pipeline.

The correction is signed:
- a stamp may be up to one second behind the reference;
- a stamp may be up to two seconds ahead of the reference.

The block accepts one stamp per cycle. Each result appears two cycles after its stamp.

Top module: `ts_sec_extend`

## Requirements
- R1: The input stamp holds nanoseconds in bits [29:0]. The result nanoseconds output equals those 30 bits unchanged.
- R2: Let d = (stamp[31:30] − reference[1:0]) mod 4. When d is 0, 1 or 2, the result seconds equal reference + d.
- R3: When d is 3, the result seconds equal reference − 1. This is a stamp one second in the past.
- R4: On every valid result, the two lowest bits of the result seconds equal bits [31:30] of the stamp that produced it.
- R5: The result valid is high exactly two clock cycles after a stamp valid, and low otherwise. Stamps on consecutive cycles give results on consecutive cycles, in order.
- R6: The reference loads from the write port at the clock edge where the write enable is high, and holds its value otherwise. A stamp accepted at the same edge as a load uses the old reference. A load while a stamp is in the pipeline does not change that stamp's result.
- R7: Result seconds wrap modulo 2^48. A reference of 0 with d = 3 gives all ones. A reference of all ones with d = 2 gives 1.
- R8: After reset, result valid is low and the reference is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_we_i | input | 1 | Load enable for the reference seconds |
| ref_sec_i | input | 48 | New reference seconds value |
| stamp_vld_i | input | 1 | Truncated stamp valid |
| stamp_i | input | 32 | Truncated stamp: seconds bits [31:30], nanoseconds [29:0] |
| ts_vld_o | output | 1 | Full timestamp valid |
| ts_sec_o | output | 48 | Full seconds |
| ts_ns_o | output | 30 | Nanoseconds |

## Verification
The assertions check these on every cycle:
- the two-cycle valid latency;
- the nanoseconds passing through unchanged;
- the two low result seconds bits matching the stamp;
- the reference holding its value when no load is made.

Only the bench scenarios can show the rest:
- the signed correction for each of the four modulo results;
- the wrap at both ends of the 48-bit range;
- the order of a load against a stamp accepted at the same edge or one already in flight.

// File: rtl/ts_ext_pkg.sv
package ts_ext_pkg;
  localparam int unsigned SEC_W_DEF  = 48;
  localparam int unsigned NS_W_DEF   = 30;
  localparam int unsigned WRAP_W_DEF = 2;

  typedef enum logic [1:0] {
    CORR_SAME  = 2'd0,
    CORR_AHEAD = 2'd1,
    CORR_PAST  = 2'd2
  } corr_kind_e;
endpackage

// File: rtl/ts_ext_ref.sv
module ts_ext_ref #(
  parameter int unsigned SEC_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEC_W-1:0] sec_i,
  output logic [SEC_W-1:0] sec_o
);
  logic [SEC_W-1:0] sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sec_q <= '0;
    else if (we_i) sec_q <= sec_i;
  end

  assign sec_o = sec_q;

  p_ref_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(sec_o));
  p_ref_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> sec_o == $past(sec_i));
endmodule

// File: rtl/ts_ext_delta.sv
module ts_ext_delta
  import ts_ext_pkg::*;
#(
  parameter int unsigned WRAP_W = 2
) (
  input  logic [WRAP_W-1:0] stamp_sec_i,
  input  logic [WRAP_W-1:0] ref_low_i,
  output logic [WRAP_W:0]   corr_o,
  output corr_kind_e        kind_o
);
  logic [WRAP_W-1:0] diff;

  always_comb begin
    diff = stamp_sec_i - ref_low_i;
    if (&diff) begin
      corr_o = '1;
      kind_o = CORR_PAST;
    end else begin
      corr_o = {1'b0, diff};
      kind_o = (diff == '0) ? CORR_SAME : CORR_AHEAD;
    end
  end
endmodule

// File: rtl/ts_ext_pipe.sv
module ts_ext_pipe
  import ts_ext_pkg::*;
#(
  parameter int unsigned SEC_W  = 48,
  parameter int unsigned NS_W   = 30,
  parameter int unsigned WRAP_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [NS_W-1:0]  ns_i,
  input  logic [SEC_W-1:0] ref_i,
  input  logic [WRAP_W:0]  corr_i,
  output logic             vld_o,
  output logic [SEC_W-1:0] sec_o,
  output logic [NS_W-1:0]  ns_o
);
  localparam int unsigned EXT_W = SEC_W - WRAP_W - 1;

  logic             s1_vld_q;
  logic [SEC_W-1:0] s1_ref_q;
  logic [WRAP_W:0]  s1_corr_q;
  logic [NS_W-1:0]  s1_ns_q;
  logic [SEC_W-1:0] corr_ext;
  logic [SEC_W-1:0] sum;

  // stage 1: single snapshot of the reference per conversion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s1_vld_q <= 1'b0;
    else         s1_vld_q <= vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (vld_i) begin
      s1_ref_q  <= ref_i;
      s1_corr_q <= corr_i;
      s1_ns_q   <= ns_i;
    end
  end

  assign corr_ext = {{EXT_W{s1_corr_q[WRAP_W]}}, s1_corr_q};
  assign sum      = s1_ref_q + corr_ext;

  // stage 2: signed add, wraps modulo 2^SEC_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_o <= 1'b0;
    else         vld_o <= s1_vld_q;
  end

  always_ff @(posedge clk_i) begin
    if (s1_vld_q) begin
      sec_o <= sum;
      ns_o  <= s1_ns_q;
    end
  end
endmodule

// File: rtl/ts_sec_extend.sv
module ts_sec_extend
  import ts_ext_pkg::*;
#(
  parameter int unsigned SEC_W  = SEC_W_DEF,
  parameter int unsigned NS_W   = NS_W_DEF,
  parameter int unsigned WRAP_W = WRAP_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ref_we_i,
  input  logic [SEC_W-1:0]         ref_sec_i,
  input  logic                     stamp_vld_i,
  input  logic [NS_W+WRAP_W-1:0]   stamp_i,
  output logic                     ts_vld_o,
  output logic [SEC_W-1:0]         ts_sec_o,
  output logic [NS_W-1:0]          ts_ns_o
);
  localparam int unsigned STAMP_W = NS_W + WRAP_W;

  logic [SEC_W-1:0] ref_q;
  logic [WRAP_W:0]  corr;
  corr_kind_e       kind;

  ts_ext_ref #(.SEC_W(SEC_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ref_we_i),
    .sec_i  (ref_sec_i),
    .sec_o  (ref_q)
  );

  ts_ext_delta #(.WRAP_W(WRAP_W)) u_delta (
    .stamp_sec_i (stamp_i[STAMP_W-1:NS_W]),
    .ref_low_i   (ref_q[WRAP_W-1:0]),
    .corr_o      (corr),
    .kind_o      (kind)
  );

  ts_ext_pipe #(.SEC_W(SEC_W), .NS_W(NS_W), .WRAP_W(WRAP_W)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (stamp_vld_i),
    .ns_i   (stamp_i[NS_W-1:0]),
    .ref_i  (ref_q),
    .corr_i (corr),
    .vld_o  (ts_vld_o),
    .sec_o  (ts_sec_o),
    .ns_o   (ts_ns_o)
  );

  p_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_vld_o == $past(stamp_vld_i, 2));
  p_ns_pass_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_vld_o |-> ts_ns_o == $past(stamp_i[NS_W-1:0], 2));
  p_low_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_vld_o |-> ts_sec_o[WRAP_W-1:0] == $past(stamp_i[STAMP_W-1:NS_W], 2));
  p_past_kind_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stamp_vld_i && kind == CORR_PAST) |-> corr == '1);
endmodule

// File: tb/sim_ts_sec_extend.sv
module sim_ts_sec_extend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_we = 1'b0;
  logic [47:0] ref_sec = '0;
  logic        st_vld = 1'b0;
  logic [31:0] stamp = '0;
  logic        ts_vld;
  logic [47:0] ts_sec;
  logic [29:0] ts_ns;
  int checks = 0;
  int errors = 0;
  logic [47:0] model_ref = '0;

  always #4 clk = ~clk;

  ts_sec_extend u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_we_i(ref_we), .ref_sec_i(ref_sec),
    .stamp_vld_i(st_vld), .stamp_i(stamp),
    .ts_vld_o(ts_vld), .ts_sec_o(ts_sec), .ts_ns_o(ts_ns)
  );

  function automatic logic [47:0] exp_sec(logic [47:0] r, logic [31:0] s);
    logic [1:0] d;
    d = s[31:30] - r[1:0];
    if (d == 2'd3) return r - 48'd1;
    return r + {46'd0, d};
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic load_ref(logic [47:0] v);
    @(negedge clk);
    ref_we = 1'b1; ref_sec = v;
    @(negedge clk);
    ref_we = 1'b0;
    model_ref = v;
  endtask

  task automatic convert(string req, logic [31:0] s);
    @(negedge clk);
    st_vld = 1'b1; stamp = s;
    @(negedge clk);
    st_vld = 1'b0;
    check({req, " idle"}, 64'(ts_vld), 64'd0);
    @(negedge clk);
    check({req, " vld"}, 64'(ts_vld), 64'd1);
    check({req, " sec"}, 64'(ts_sec), 64'(exp_sec(model_ref, s)));
    check({req, " R1 ns"}, 64'(ts_ns), 64'(s[29:0]));
    @(negedge clk);
    check({req, " R5 single"}, 64'(ts_vld), 64'd0);
  endtask

  task automatic t_reset();
    check("R8 vld", 64'(ts_vld), 64'd0);
    convert("R8 zero ref", {2'd0, 30'd12345});
  endtask

  task automatic t_ahead();
    load_ref(48'd1000);
    convert("R2 d0", {2'd0, 30'd1});
    convert("R2 d1", {2'd1, 30'd999_999_999});
    convert("R2 d2", {2'd2, 30'd500});
    load_ref(48'd1003);
    convert("R2 ref3", {2'd0, 30'd7});
  endtask

  task automatic t_past();
    load_ref(48'd1000);
    convert("R3 d3", {2'd3, 30'd42});
    load_ref(48'd1002);
    convert("R3 ref2", {2'd1, 30'd43});
  endtask

  task automatic t_wrap();
    load_ref(48'd0);
    convert("R7 low", {2'd3, 30'd9});
    load_ref('1);
    convert("R7 high", {2'd1, 30'd10});
  endtask

  task automatic t_stream();
    logic [31:0] s [3];
    s[0] = {2'd0, 30'd100}; s[1] = {2'd1, 30'd200}; s[2] = {2'd3, 30'd300};
    load_ref(48'd5000);
    @(negedge clk); st_vld = 1'b1; stamp = s[0];
    @(negedge clk); stamp = s[1];
    @(negedge clk);
    check("R5 first", 64'(ts_vld), 64'd1);
    check("R5 sec0", 64'(ts_sec), 64'(exp_sec(model_ref, s[0])));
    stamp = s[2];
    @(negedge clk);
    st_vld = 1'b0;
    check("R5 sec1", 64'(ts_sec), 64'(exp_sec(model_ref, s[1])));
    check("R4 low1", 64'(ts_sec[1:0]), 64'(s[1][31:30]));
    @(negedge clk);
    check("R5 vld2", 64'(ts_vld), 64'd1);
    check("R5 sec2", 64'(ts_sec), 64'(exp_sec(model_ref, s[2])));
    check("R5 ns2", 64'(ts_ns), 64'(s[2][29:0]));
    @(negedge clk);
    check("R5 drain", 64'(ts_vld), 64'd0);
  endtask

  task automatic t_load_order();
    logic [47:0] old_ref;
    load_ref(48'd2000);
    old_ref = model_ref;
    @(negedge clk);
    st_vld = 1'b1; stamp = {2'd1, 30'd11};
    ref_we = 1'b1; ref_sec = 48'd9000;
    @(negedge clk);
    st_vld = 1'b0; ref_we = 1'b0;
    @(negedge clk);
    check("R6 same edge", 64'(ts_sec), 64'(exp_sec(old_ref, {2'd1, 30'd11})));
    model_ref = 48'd9000;
    convert("R6 new ref", {2'd0, 30'd12});
    old_ref = model_ref;
    @(negedge clk);
    st_vld = 1'b1; stamp = {2'd2, 30'd13};
    @(negedge clk);
    st_vld = 1'b0; ref_we = 1'b1; ref_sec = 48'd77;
    @(negedge clk);
    ref_we = 1'b0;
    check("R6 in flight", 64'(ts_sec), 64'(exp_sec(old_ref, {2'd2, 30'd13})));
    model_ref = 48'd77;
    convert("R6 after", {2'd1, 30'd14});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ahead();
    t_past();
    t_wrap();
    t_stream();
    t_load_order();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule